// File: doc/BRIEF.md
# OSD Horizontal Character Timing Generator

This block produces the horizontal timing for a character-based on-screen display. It runs on a pixel clock that is assumed to already track the horizontal flyback rate. It watches the flyback input for its leading edge and restarts a pixel counter there. From that point it opens a display window: 30 character cells of 12 dots each. The window starts at a delay set by a position register.

While the window is open, the block reports which character column and which dot inside the cell is being drawn. A font lookup and colour stage downstream use these indices.

The line length comes from a resolution register: 12 pixel clocks per unit. A double-width bit makes every dot last two pixel clocks. All three controls are captured only at a flyback edge. When no flyback arrives, the counter wraps at the line length and the line timing repeats by itself.

Top module: `hcell_timing`

## Requirements
- R1: In reset, and after reset when no flyback edge has been seen, `dispEn` is 0, and `colIdx` and `dotIdx` are 0.
- R2: A rising edge on `flybackIn` restarts the line. Let d = `posReg`×6 + 49, counted in pixel clocks from the restart. `dispEn` is 0 three clocks after the input rises, and it rises d+3 clocks after the input rises. The three clocks are two synchronizer stages plus one edge register. A restart during an open window closes that window.
- R3: With double width off, the window lasts 360 clocks. `dotIdx` counts 0 to 11 with one clock per dot. `colIdx` starts at 0 and steps by one after dot 11, up to 29. In the k-th window clock (k from 0), dot = k mod 12 and column = k div 12.
- R4: With double width on, each dot value is held for 2 clocks and the window lasts 720 clocks. In the k-th window clock, dot = (k/2) mod 12 and column = (k/2) div 12.
- R5: The line length L is `resReg`×12 pixel clocks. A window that would run past L closes at L, so its width is L − d. No window opens when L ≤ d.
- R6: When no new flyback edge arrives, the pixel count wraps to 0 at L and the window repeats every L clocks. The gap between the end of one window and the start of the next is L minus the window width.
- R7: Changes to `posReg`, `resReg` and `dblWidth` have no effect until the next flyback leading edge. This applies to the current window and to the free-running lines that follow it.
- R8: Whenever `dispEn` is 0, `colIdx` and `dotIdx` read 0.
- R9: Only the leading edge of the flyback matters. Holding `flybackIn` high, or its falling edge, causes no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flybackIn | input | 1 | Horizontal flyback, asynchronous, leading edge active |
| posReg | input | 7 | Horizontal position: start delay = value×6+49 pixels |
| resReg | input | 8 | Horizontal resolution: line length = value×12 pixels |
| dblWidth | input | 1 | 1 = each dot lasts two pixel clocks |
| dispEn | output | 1 | Display window open |
| colIdx | output | 5 | Character column, 0 to 29 |
| dotIdx | output | 4 | Dot within the cell, 0 to 11 |

## Verification
A wrong pixel count shows up at the ports on the next line. The window opens at the wrong clock after the flyback, or it repeats with the wrong gap when the line runs freely. A corrupted cell or column counter puts a wrong index on `dotIdx` or `colIdx` within one clock. It also moves the end of the window, because the window closes on the last dot of column 29, so the width comes out wrong in the same line. A register latched at the wrong time makes the window width or position change in the middle of a line. The bench catches this by altering the controls while a window is open.

// File: rtl/hcell_pkg.sv
package hcell_pkg;
  // Strobes sent from the line controller to the cell counters
  typedef struct packed {
    logic advance; // window open: step the cell counters
    logic clear;   // window closed: hold counters at zero
    logic dbl;     // latched double-width mode
  } hcell_strobe_t;
endpackage

// File: rtl/hcell_ctrl.sv
module hcell_ctrl
  import hcell_pkg::*;
#(
  parameter int POS_W       = 7,
  parameter int RES_W       = 8,
  parameter int CELL_DOTS   = 12,
  parameter int POS_STEP    = 6,
  parameter int POS_OFFSET  = 49,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flybackIn,
  input  logic [POS_W-1:0] posReg,
  input  logic [RES_W-1:0] resReg,
  input  logic             dblWidth,
  input  logic             lastDot,
  output hcell_strobe_t    strobe,
  output logic             dispEn
);
  localparam int CNT_MAX = (2**RES_W - 1) * CELL_DOTS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int DLY_MAX = (2**POS_W - 1) * POS_STEP + POS_OFFSET;
  localparam int DLY_W   = $clog2(DLY_MAX + 1);
  localparam int CMP_W   = ((CNT_W > DLY_W) ? CNT_W : DLY_W) + 1;
  localparam logic [CMP_W-1:0] K_DOTS   = CMP_W'(CELL_DOTS);
  localparam logic [CMP_W-1:0] K_STEP   = CMP_W'(POS_STEP);
  localparam logic [CMP_W-1:0] K_OFFSET = CMP_W'(POS_OFFSET);

  // Flyback synchronizer plus one extra stage for edge detection
  logic [SYNC_STAGES:0] syncQ;
  logic                 edgeDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], flybackIn};
  end

  assign edgeDet = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

  // Control registers captured on the flyback leading edge
  logic [POS_W-1:0] posQ;
  logic [RES_W-1:0] resQ;
  logic             dblQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posQ <= '0;
      resQ <= '0;
      dblQ <= 1'b0;
    end else if (edgeDet) begin
      posQ <= posReg;
      resQ <= resReg;
      dblQ <= dblWidth;
    end
  end

  // Line geometry derived from the captured registers
  logic [CMP_W-1:0] lineLen;
  logic [CMP_W-1:0] delayVal;
  logic [CMP_W-1:0] pixNext;
  logic [CNT_W-1:0] pixCnt;
  logic             lineEnd;

  assign lineLen  = CMP_W'(resQ) * K_DOTS;
  assign delayVal = CMP_W'(posQ) * K_STEP + K_OFFSET;
  assign pixNext  = CMP_W'(pixCnt) + CMP_W'(1);
  assign lineEnd  = (pixNext >= lineLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        pixCnt <= '0;
    else if (edgeDet) pixCnt <= '0;
    else if (lineEnd) pixCnt <= '0;
    else              pixCnt <= pixCnt + CNT_W'(1);
  end

  // Window closes after the last dot of the last column
  logic doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   doneQ <= 1'b0;
    else if (edgeDet || lineEnd) doneQ <= 1'b0;
    else if (lastDot)            doneQ <= 1'b1;
  end

  assign dispEn         = (CMP_W'(pixCnt) >= delayVal) && !doneQ;
  assign strobe.advance = dispEn;
  assign strobe.clear   = !dispEn;
  assign strobe.dbl     = dblQ;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (lineLen == '0) || (CMP_W'(pixCnt) < lineLen)) else $error("pixel count past line end"); // R6

  AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    edgeDet |=> (pixCnt == '0) && !dispEn) else $error("flyback edge did not restart line"); // R2

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(edgeDet) |-> ($stable(posQ) && $stable(resQ) && $stable(dblQ))) else $error("controls changed without edge"); // R7

  AST_LEVEL_ONLY_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    edgeDet |=> !edgeDet) else $error("edge detector fired twice"); // R9
endmodule

// File: rtl/hcell_dpath.sv
module hcell_dpath
  import hcell_pkg::*;
#(
  parameter int CELL_DOTS = 12,
  parameter int COLS      = 30
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  hcell_strobe_t                strobe,
  output logic                         lastDot,
  output logic [$clog2(COLS)-1:0]      colIdx,
  output logic [$clog2(CELL_DOTS)-1:0] dotIdx
);
  localparam int DOT_W = $clog2(CELL_DOTS);
  localparam int COL_W = $clog2(COLS);
  localparam logic [DOT_W-1:0] LAST_DOT = DOT_W'(CELL_DOTS - 1);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  logic             halfQ;
  logic [DOT_W-1:0] dotQ;
  logic [COL_W-1:0] colQ;
  logic             dotDone;

  // A dot is finished on every clock, or on every second one in double width
  assign dotDone = !strobe.dbl || halfQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfQ <= 1'b0;
      dotQ  <= '0;
      colQ  <= '0;
    end else if (strobe.clear) begin
      halfQ <= 1'b0;
      dotQ  <= '0;
      colQ  <= '0;
    end else if (strobe.advance) begin
      if (!dotDone) begin
        halfQ <= 1'b1;
      end else begin
        halfQ <= 1'b0;
        if (dotQ == LAST_DOT) begin
          dotQ <= '0;
          colQ <= (colQ == LAST_COL) ? '0 : colQ + COL_W'(1);
        end else begin
          dotQ <= dotQ + DOT_W'(1);
        end
      end
    end
  end

  assign lastDot = strobe.advance && dotDone && (dotQ == LAST_DOT) && (colQ == LAST_COL);
  assign colIdx  = strobe.advance ? colQ : '0;
  assign dotIdx  = strobe.advance ? dotQ : '0;

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (dotQ <= LAST_DOT) && (colQ <= LAST_COL)) else $error("cell index out of range"); // R3

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.advance) |-> (dotQ == '0) && (colQ == '0) && !halfQ) else $error("window began mid-cell"); // R3

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.dbl && $past(strobe.advance) && !$past(strobe.dbl)) |-> (dotIdx != $past(dotIdx))) else $error("dot held in single width"); // R3

  AST_DOUBLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && strobe.dbl && halfQ && $past(strobe.advance)) |-> (dotIdx == $past(dotIdx))) else $error("dot not held in double width"); // R4

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |-> (colIdx == '0) && (dotIdx == '0)) else $error("index nonzero outside window"); // R8
endmodule

// File: rtl/hcell_timing.sv
module hcell_timing
  import hcell_pkg::*;
#(
  parameter int POS_W      = 7,
  parameter int RES_W      = 8,
  parameter int CELL_DOTS  = 12,
  parameter int COLS       = 30,
  parameter int POS_STEP   = 6,
  parameter int POS_OFFSET = 49
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         flybackIn,
  input  logic [POS_W-1:0]             posReg,
  input  logic [RES_W-1:0]             resReg,
  input  logic                         dblWidth,
  output logic                         dispEn,
  output logic [$clog2(COLS)-1:0]      colIdx,
  output logic [$clog2(CELL_DOTS)-1:0] dotIdx
);
  hcell_strobe_t strobe;
  logic          lastDot;

  hcell_ctrl #(
    .POS_W(POS_W), .RES_W(RES_W), .CELL_DOTS(CELL_DOTS),
    .POS_STEP(POS_STEP), .POS_OFFSET(POS_OFFSET), .SYNC_STAGES(2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .flybackIn(flybackIn), .posReg(posReg),
    .resReg(resReg), .dblWidth(dblWidth), .lastDot(lastDot),
    .strobe(strobe), .dispEn(dispEn)
  );

  hcell_dpath #(
    .CELL_DOTS(CELL_DOTS), .COLS(COLS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lastDot(lastDot),
    .colIdx(colIdx), .dotIdx(dotIdx)
  );
endmodule

// File: tb/hcell_timing_tb.sv
`timescale 1ns/1ps
module hcell_timing_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       flybackIn = 1'b0;
  logic [6:0] posReg = '0;
  logic [7:0] resReg = '0;
  logic       dblWidth = 1'b0;
  logic       dispEn;
  logic [4:0] colIdx;
  logic [3:0] dotIdx;

  hcell_timing u_dut (
    .clk(clk), .rstN(rstN), .flybackIn(flybackIn), .posReg(posReg),
    .resReg(resReg), .dblWidth(dblWidth), .dispEn(dispEn),
    .colIdx(colIdx), .dotIdx(dotIdx)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  int tCnt    = 0;
  int holdLeft = 0;

  // Vector table: position, resolution, double width, expected latency (0 = none), expected width
  localparam int NVEC = 7;
  localparam int VPOS[NVEC] = '{0,   10,  127, 20,  5,   3, 1};
  localparam int VRES[NVEC] = '{100, 100, 90,  40,  255, 5, 31};
  localparam int VDBL[NVEC] = '{0,   1,   1,   0,   0,   0, 1};
  localparam int VLAT[NVEC] = '{52,  112, 814, 172, 82,  0, 58};
  localparam int VWID[NVEC] = '{360, 720, 269, 311, 360, 0, 317};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    tCnt++;
    if (holdLeft > 0) begin
      holdLeft--;
      if (holdLeft == 0) flybackIn = 1'b0;
    end
  endtask

  task automatic startLine(input int pos, input int res, input int dbl, input int hold);
    @(negedge clk);
    posReg    = 7'(pos);
    resReg    = 8'(res);
    dblWidth  = dbl[0];
    flybackIn = 1'b1;
    holdLeft  = hold;
    tCnt      = 0;
  endtask

  task automatic waitRise(input int limit, output int lat);
    lat = -1;
    while (tCnt < limit) begin
      tick();
      if (tCnt >= 3 && dispEn) begin
        lat = tCnt;
        break;
      end
    end
  endtask

  task automatic measureWindow(input int dbl, output int wid, output int seqErr);
    wid = 0;
    seqErr = 0;
    while (dispEn && wid < 2000) begin
      int k;
      k = wid >> dbl;
      if (int'(dotIdx) != k % 12 || int'(colIdx) != k / 12) seqErr++;
      wid++;
      tick();
    end
  endtask

  task automatic measureGap(input int limit, output int gap);
    gap = 0;
    while (!dispEn && gap < limit) begin
      gap++;
      tick();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int lat, wid, seqErr, gap;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(dispEn == 1'b0, "R1 enable in reset", int'(dispEn), 0);
    check(colIdx == '0 && dotIdx == '0, "R1 indices in reset", int'({colIdx, dotIdx}), 0);
    rstN = 1'b1;
    repeat (200) @(negedge clk);
    check(dispEn == 1'b0 && colIdx == '0 && dotIdx == '0, "R1 idle before flyback",
          int'({dispEn, colIdx, dotIdx}), 0);

    // Table walk: R2 latency, R3/R4 width and sequence, R5 truncation
    for (int v = 0; v < NVEC; v++) begin
      startLine(VPOS[v], VRES[v], VDBL[v], 4);
      waitRise((VLAT[v] > 0) ? VLAT[v] + 5 : 1500, lat);
      if (VLAT[v] == 0) begin
        check(lat == -1, "R5 no window when line too short", lat, -1);
      end else begin
        check(lat == VLAT[v], "R2 start latency", lat, VLAT[v]);
        measureWindow(VDBL[v], wid, seqErr);
        if (VWID[v] < (VDBL[v] != 0 ? 720 : 360))
          check(wid == VWID[v], "R5 truncated width", wid, VWID[v]);
        else if (VDBL[v] != 0)
          check(wid == VWID[v], "R4 double width", wid, VWID[v]);
        else
          check(wid == VWID[v], "R3 single width", wid, VWID[v]);
        check(seqErr == 0, (VDBL[v] != 0) ? "R4 index sequence" : "R3 index sequence", seqErr, 0);
        check(colIdx == '0 && dotIdx == '0, "R8 indices after window", int'({colIdx, dotIdx}), 0);
      end
    end

    // R6: free-running wrap, line length 120, delay 49
    startLine(0, 10, 0, 4);
    waitRise(60, lat);
    check(lat == 52, "R6 first start", lat, 52);
    measureWindow(0, wid, seqErr);
    check(wid == 71, "R6 first width", wid, 71);
    measureGap(500, gap);
    check(gap == 49, "R6 gap after wrap", gap, 49);
    measureWindow(0, wid, seqErr);
    check(wid == 71 && seqErr == 0, "R6 repeated window", wid, 71);

    // R7: register changes mid-line are ignored until the next edge
    startLine(10, 100, 0, 4);
    waitRise(120, lat);
    check(lat == 112, "R7 start", lat, 112);
    posReg = 7'd0;
    resReg = 8'd20;
    dblWidth = 1'b1;
    measureWindow(0, wid, seqErr);
    check(wid == 360 && seqErr == 0, "R7 window unchanged", wid, 360);
    measureGap(2000, gap);
    check(gap == 840, "R7 free-run gap unchanged", gap, 840);

    // R9: flyback held high causes no restart
    startLine(0, 100, 0, 600);
    waitRise(60, lat);
    check(lat == 52, "R9 start", lat, 52);
    measureWindow(0, wid, seqErr);
    check(wid == 360 && seqErr == 0, "R9 width with held flyback", wid, 360);
    measureGap(2000, gap);
    check(gap == 840, "R9 no restart on level or fall", gap, 840);

    // R2: a new edge mid-window closes the window and restarts
    startLine(0, 100, 0, 4);
    waitRise(60, lat);
    repeat (100) tick();
    startLine(0, 100, 0, 4);
    repeat (3) tick();
    check(dispEn == 1'b0, "R2 restart closes window", int'(dispEn), 0);
    waitRise(60, lat);
    check(lat == 52, "R2 restart latency", lat, 52);
    measureWindow(0, wid, seqErr);
    check(wid == 360 && seqErr == 0, "R2 full window after restart", wid, 360);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule